// File: doc/BRIEF.md
# Load Switch Fault Qualifier

This block turns the raw, already digitised condition signals of a bank of load switch channels into one latched fault flag per channel, ready for a serial status interface to shift out. For each channel it sees three indications (drain-source voltage under the fault threshold, overcurrent, overtemperature), together with the channel's present on/off command and its open-load sense current enable. What counts as a fault depends on the command: a switched-on channel reports overcurrent, an off channel reports a low drain-source voltage only while its sense current is enabled, and overtemperature is reported in either state.

Switching edges disturb the comparators, so a blanking timer masks all detection for a programmable number of clock cycles after each command update and after leaving sleep. Flags are sticky: once set, a flag stays set until the serial interface signals that it has captured the status word. On that capture the flags are reloaded with whatever qualified condition is still present, so a persisting fault is reported again in the next frame. While the block is asleep or in reset every flag is held at 0.

The timer is a three-state machine. SLEEP is held while `awake` is low. Transition WAKE goes from SLEEP to BLANK and loads the timer. In BLANK the timer counts down; transition EXPIRE goes to WATCH when it reaches zero, and transition RESTART reloads it on a command update. From WATCH, transition UPDATE returns to BLANK. Transition DOZE goes from any state to SLEEP when `awake` falls.

Top module: `load_fault_qualifier`

## Requirements
- R1: While `rst_n` is low or `awake` is low, every bit of `fault_flags` is 0 and `watch_active` is 0 from the first clock edge on.
- R2: A channel whose `cmd_on` bit is 0, whose `detect_en` bit is 1 and whose `vds_low` bit is 1 sets its `fault_flags` bit.
- R3: A channel whose `cmd_on` bit is 0 and whose `detect_en` bit is 0 never sets its flag from `vds_low`.
- R4: A channel whose `cmd_on` bit is 1 sets its flag on `over_current`, whatever its `detect_en` bit.
- R5: A channel sets its flag on `over_temp` whether it is on or off and whatever its `detect_en` bit.
- R6: A channel whose `cmd_on` bit is 1 never sets its flag from `vds_low` (an open load while on is not reported).
- R7: A `cmd_update` pulse drops `watch_active` on the next edge and starts a blanking window of `BLANK_CYCLES` clock cycles; no flag can rise while blanking, and `watch_active` returns to 1 only after the window has run out with no further update.
- R8: A set flag stays set after its condition goes away, until a capture or sleep.
- R9: On a clock edge with `capture` high, each flag takes the value of its qualified condition at that edge: it clears if the condition is gone and stays 1 if it persists.
- R10: Flag bit i belongs to channel i only; bit i of every input vector affects only bit i of `fault_flags`.
- R11: When `awake` rises, the block blanks for `BLANK_CYCLES` cycles before any flag can be set, just as after a command update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awake | input | 1 | High when the device is enabled; low means sleep |
| cmd_update | input | 1 | One-cycle pulse when a new command word takes effect |
| cmd_on | input | NUM_CH | Present on/off command per channel (1 = on) |
| detect_en | input | NUM_CH | Open-load sense current enable per channel (1 = enabled) |
| vds_low | input | NUM_CH | Drain-source voltage below fault threshold, per channel |
| over_current | input | NUM_CH | Overcurrent indication per channel |
| over_temp | input | NUM_CH | Overtemperature indication per channel |
| capture | input | 1 | One-cycle pulse when the status word is captured for shifting out |
| fault_flags | output | NUM_CH | Latched fault flag per channel |
| watch_active | output | 1 | High when detection is live (blanking window over) |

## Verification
The bench probes the edges of the blanking window: a fault already present during blanking must stay hidden one cycle short of expiry and appear after it, so a timer off by a few cycles or one that is not restarted by an update would show a flag too early. It crosses the command state with every indication, since a design that decoded the condition without looking at the on/off bit would report open loads on driven channels or overcurrent on idle ones, and one that gated overtemperature by the sense enable would miss thermal faults. Capture is driven both with the condition gone and with it persisting, catching a latch that never clears or one that drops a still-present fault for a frame. Sleep in the middle of a latched fault checks that the flags clear and that waking re-blanks instead of flagging at once.

// File: rtl/lfq_pkg.sv
package lfq_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'b00,
        ST_BLANK = 2'b01,
        ST_WATCH = 2'b10
    } blank_state_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/lfq_sync.sv
module lfq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/lfq_blank_fsm.sv
module lfq_blank_fsm
    import lfq_pkg::*;
#(
    parameter int BLANK_CYCLES = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic awake,
    input  logic cmd_update,
    output logic watch_active,
    output logic sample_en
);

    localparam int CW = cnt_width(BLANK_CYCLES);
    localparam logic [CW-1:0] LOAD_VAL = CW'(BLANK_CYCLES - 1);

    blank_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state and timer logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!awake) begin
            state_d = ST_SLEEP;                 // DOZE
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_SLEEP: begin
                    state_d = ST_BLANK;         // WAKE
                    cnt_d   = LOAD_VAL;
                end
                ST_BLANK: begin
                    if (cmd_update) begin
                        cnt_d = LOAD_VAL;       // RESTART
                    end else if (cnt_q == '0) begin
                        state_d = ST_WATCH;     // EXPIRE
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_WATCH: begin
                    if (cmd_update) begin
                        state_d = ST_BLANK;     // UPDATE
                        cnt_d   = LOAD_VAL;
                    end
                end
                default: begin
                    state_d = ST_SLEEP;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        watch_active = (state_q == ST_WATCH);
        sample_en    = (state_q == ST_WATCH) && !cmd_update && awake;
    end

endmodule

// File: rtl/lfq_channel.sv
module lfq_channel (
    input  logic clk,
    input  logic rst_n,
    input  logic awake,
    input  logic sample_en,
    input  logic capture,
    input  logic is_on,
    input  logic sense_en,
    input  logic vds_low,
    input  logic oc,
    input  logic ot,
    output logic flag
);

    logic cond;
    logic held;

    // qualified condition: thermal always, overcurrent when driven,
    // low drain voltage only when off with sense current enabled
    always_comb begin
        if (is_on) cond = ot | oc;
        else       cond = ot | (sense_en & vds_low);
    end

    always_comb held = capture ? 1'b0 : flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag <= 1'b0;
        else if (!awake) flag <= 1'b0;
        else             flag <= held | (sample_en & cond);
    end

endmodule

// File: rtl/load_fault_qualifier.sv
module load_fault_qualifier #(
    parameter int NUM_CH       = 8,
    parameter int BLANK_CYCLES = 25000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awake,
    input  logic              cmd_update,
    input  logic [NUM_CH-1:0] cmd_on,
    input  logic [NUM_CH-1:0] detect_en,
    input  logic [NUM_CH-1:0] vds_low,
    input  logic [NUM_CH-1:0] over_current,
    input  logic [NUM_CH-1:0] over_temp,
    input  logic              capture,
    output logic [NUM_CH-1:0] fault_flags,
    output logic              watch_active
);

    localparam int IND_W = 3 * NUM_CH;

    logic [IND_W-1:0]  ind_raw, ind_sync;
    logic [NUM_CH-1:0] vds_s, oc_s, ot_s;
    logic              sample_en;

    assign ind_raw = {over_temp, over_current, vds_low};
    assign vds_s   = ind_sync[NUM_CH-1:0];
    assign oc_s    = ind_sync[2*NUM_CH-1:NUM_CH];
    assign ot_s    = ind_sync[IND_W-1:2*NUM_CH];

    lfq_sync #(.WIDTH(IND_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ind_raw),
        .dout (ind_sync)
    );

    lfq_blank_fsm #(.BLANK_CYCLES(BLANK_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .awake       (awake),
        .cmd_update  (cmd_update),
        .watch_active(watch_active),
        .sample_en   (sample_en)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            lfq_channel u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .awake    (awake),
                .sample_en(sample_en),
                .capture  (capture),
                .is_on    (cmd_on[c]),
                .sense_en (detect_en[c]),
                .vds_low  (vds_s[c]),
                .oc       (oc_s[c]),
                .ot       (ot_s[c]),
                .flag     (fault_flags[c])
            );
        end
    endgenerate

endmodule

// File: rtl/load_fault_qualifier_chk.sv
module load_fault_qualifier_chk #(
    parameter int NUM_CH       = 8,
    parameter int BLANK_CYCLES = 25000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              awake,
    input logic              cmd_update,
    input logic              capture,
    input logic [NUM_CH-1:0] fault_flags,
    input logic              watch_active
);

    localparam int QW = $clog2(BLANK_CYCLES + 2) + 1;

    logic [QW-1:0] quiet_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      quiet_cnt <= '0;
        else if (cmd_update || !awake)   quiet_cnt <= '0;
        else if (quiet_cnt < QW'(BLANK_CYCLES)) quiet_cnt <= quiet_cnt + 1'b1;
    end

    // R1
    sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> (fault_flags == '0) && !watch_active);

    // R7
    update_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_update |=> !watch_active);

    // R7
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        watch_active |-> (quiet_cnt >= QW'(BLANK_CYCLES)));

    // R7
    rise_when_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_flags & ~$past(fault_flags)) != '0) |-> $past(watch_active && !cmd_update));

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !capture) |=> ((fault_flags & $past(fault_flags)) == $past(fault_flags)));

endmodule

bind load_fault_qualifier load_fault_qualifier_chk #(
    .NUM_CH(NUM_CH),
    .BLANK_CYCLES(BLANK_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .awake       (awake),
    .cmd_update  (cmd_update),
    .capture     (capture),
    .fault_flags (fault_flags),
    .watch_active(watch_active)
);

// File: tb/load_fault_qualifier_test.sv
module load_fault_qualifier_test;

    localparam int N  = 8;
    localparam int BC = 40;

    logic         clk = 1'b0;
    logic         rst_n, awake, cmd_update, capture;
    logic [N-1:0] cmd_on, detect_en, vds_low, over_current, over_temp;
    logic [N-1:0] fault_flags;
    logic         watch_active;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    load_fault_qualifier #(.NUM_CH(N), .BLANK_CYCLES(BC), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .awake(awake), .cmd_update(cmd_update),
        .cmd_on(cmd_on), .detect_en(detect_en), .vds_low(vds_low),
        .over_current(over_current), .over_temp(over_temp),
        .capture(capture), .fault_flags(fault_flags), .watch_active(watch_active)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_inputs();
        vds_low = '0; over_current = '0; over_temp = '0;
    endtask

    task automatic do_capture();
        capture = 1'b1; cyc(1); capture = 1'b0; cyc(1);
    endtask

    // new command word, then wait out the window
    task automatic update_and_wait(input logic [N-1:0] on, input logic [N-1:0] den);
        cmd_on = on; detect_en = den; cmd_update = 1'b1;
        cyc(1); cmd_update = 1'b0;
        cyc(BC + 3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; awake = 1'b0; cmd_update = 1'b0; capture = 1'b0;
        cmd_on = '0; detect_en = '0; clear_inputs();
        cyc(3);
        chk("R1 flags in reset", fault_flags, 0);
        chk("R1 watch in reset", watch_active, 0);
        rst_n = 1'b1; vds_low = '1; detect_en = '1;
        cyc(4);
        chk("R1 flags asleep", fault_flags, 0);
        chk("R1 watch asleep", watch_active, 0);
        clear_inputs(); detect_en = '0;
    endtask

    task automatic t_wake();
        awake = 1'b1;
        cyc(BC - 1);
        chk("R11 blank after wake", watch_active, 0);
        cyc(5);
        chk("R11 live after wake", watch_active, 1);
    endtask

    task automatic t_blank_open_off();
        cmd_on = '0; detect_en = '1; cmd_update = 1'b1; vds_low = 8'h01;
        cyc(1); cmd_update = 1'b0;
        chk("R7 watch drops on update", watch_active, 0);
        cyc(BC - 2);
        chk("R7 flag hidden in window", fault_flags, 0);
        chk("R7 still blanking", watch_active, 0);
        cyc(6);
        chk("R7 live after window", watch_active, 1);
        chk("R2 open load off with sense", fault_flags, 8'h01);
        clear_inputs(); cyc(4); do_capture();
        chk("R9 cleared when gone", fault_flags, 0);
    endtask

    task automatic t_restart();
        cmd_on = '0; detect_en = '1; cmd_update = 1'b1;
        cyc(1); cmd_update = 1'b0;
        cyc(BC / 2);
        vds_low = 8'h80; cmd_update = 1'b1;
        cyc(1); cmd_update = 1'b0;
        cyc(BC - 2);
        chk("R7 restart extends blanking", fault_flags, 0);
        cyc(6);
        chk("R7 flag after restarted window", fault_flags, 8'h80);
        clear_inputs(); cyc(4); do_capture();
    endtask

    task automatic t_open_disabled();
        update_and_wait('0, '0);
        vds_low = '1; cyc(6);
        chk("R3 no open load without sense", fault_flags, 0);
        clear_inputs(); cyc(4);
    endtask

    task automatic t_on_faults();
        update_and_wait('1, '0);
        vds_low = '1; cyc(6);
        chk("R6 open while on ignored", fault_flags, 0);
        over_current = 8'h5A; cyc(6);
        chk("R4 overcurrent while on", fault_flags, 8'h5A);
        clear_inputs(); cyc(6);
        chk("R8 sticky after removal", fault_flags, 8'h5A);
        do_capture();
        chk("R9 capture clears", fault_flags, 0);
    endtask

    task automatic t_overtemp();
        update_and_wait(8'h0F, 8'h00);
        over_temp = 8'hF1; cyc(6);
        chk("R5 overtemp on and off", fault_flags, 8'hF1);
        do_capture();
        chk("R9 persisting fault kept", fault_flags, 8'hF1);
        clear_inputs(); cyc(4); do_capture();
        chk("R9 cleared after removal", fault_flags, 0);
    endtask

    task automatic t_mixed();
        update_and_wait(8'hAA, 8'h0F);
        vds_low = '1; over_current = '1; cyc(6);
        chk("R10 per channel decode", fault_flags, 8'hAF);
        clear_inputs(); cyc(4); do_capture();
        over_current = 8'h04; vds_low = 8'h20; cyc(6);
        chk("R10 off bit oc and on bit vds", fault_flags, 0);
        clear_inputs(); cyc(4);
    endtask

    task automatic t_sleep();
        update_and_wait('0, '1);
        vds_low = 8'h3C; cyc(6);
        chk("R2 set before sleep", fault_flags, 8'h3C);
        awake = 1'b0; cyc(2);
        chk("R1 sleep clears flags", fault_flags, 0);
        chk("R1 sleep drops watch", watch_active, 0);
        awake = 1'b1; cyc(BC - 1);
        chk("R11 no flag while waking", fault_flags, 0);
        cyc(6);
        chk("R11 relatch after wake window", fault_flags, 8'h3C);
        clear_inputs(); cyc(4); do_capture();
    endtask

    initial begin
        int cnt = 0;
        while (!done && cnt < 100000) begin
            @(posedge clk); cnt++;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_wake();
        t_blank_open_off();
        t_restart();
        t_open_disabled();
        t_on_faults();
        t_overtemp();
        t_mixed();
        t_sleep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule